// File: doc/BRIEF.md
# Logic Self-Test Wrapper with Signature Compare

This block wraps a small combinational circuit under test so that the circuit can test itself on command. While idle, the wrapper is transparent. The functional input is routed to the circuit's inputs, and the circuit's outputs are returned as the functional output. The pattern generator and the signature register keep their values and do not advance.

A one-cycle start command begins a test, which runs in order:
- The wrapper loads the generator and compactor seeds.
- It steers pseudo-random patterns into the circuit and the circuit's responses into a multiple-input signature register, for a fixed number of cycles.
- It compares the final signature with a golden value given as a parameter.
- It raises done and reports pass or fail, then returns the routing to normal.

The circuit itself sits outside the top module and connects through a drive/response port pair. A system can therefore place the wrapper around any small combinational function. A bench can also inject faults into that function.

Top module: `lbist_wrap`

## Requirements
- R1: After synchronous reset, busy, done and fail are all 0 and the wrapper is in normal routing.
- R2: While busy is 0, cut_drive equals func_in and func_out equals cut_resp for every input value. The generator and signature register do not change.
- R3: A start pulse sampled while idle makes busy 1 from the next cycle. busy stays 1 through seeding, CYCLES run cycles and one compare cycle. done rises and busy falls on the edge CYCLES+2 cycles after the start edge.
- R4: During the run cycles, cut_drive carries the generator sequence. It starts at the seed 4'b1000. Each next value shifts the state left and places in bit 0 the XOR of the state bits selected by the tap mask (mask 4'b1100). A 15-cycle run therefore presents 15 distinct nonzero patterns and never the all-zero pattern.
- R5: While busy is 1, func_out is held at 0, which isolates the circuit from the functional side.
- R6: The signature register starts at 0. On each run cycle it shifts left, places the tap-masked XOR feedback (mask 3'b110) in bit 0, and XORs the response word into the result bit by bit.
- R7: fail is 1 exactly when the final signature differs from GOLDEN. A fault-free circuit passes, and a faulty circuit fails whenever its signature differs.
- R8: done and fail keep their values until the next accepted start, which clears them, or until reset.
- R9: A start pulse while busy is 1 has no effect. The pattern sequence, the completion time and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Test request pulse |
| func_in | input | PAT_W | Functional value for the circuit inputs |
| func_out | output | SIG_W | Functional result, 0 while testing |
| cut_drive | output | PAT_W | Drives the circuit under test inputs |
| cut_resp | input | SIG_W | Outputs of the circuit under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, result valid |
| fail | output | 1 | Signature mismatch |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that start is a clean synchronous level and that cut_resp depends only on cut_drive within the same cycle. The bench meets these assumptions as follows:
- It drives start and func_in only at falling edges.
- It holds reset for several edges.
- It models the circuit as a pure function of cut_drive, with a selectable stuck fault that changes only between tests.

The stimulus sweeps every functional input value in normal mode and runs complete tests under four circuit variants, one of them with a start pulse issued in the middle of a run.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2,
        ST_CMP  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic load;     // reseed generator and compactor
        logic adv;      // advance generator and compactor
        logic route;    // steer patterns into the circuit
        logic isolate;  // block functional output
    } bist_ctl_t;

    localparam int MAX_W = 32;

    // XOR of the state bits selected by a tap mask
    function automatic logic fb_bit(logic [MAX_W-1:0] s, logic [MAX_W-1:0] m);
        return ^(s & m);
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
    import lbist_pkg::*;
#(
    parameter int             W    = 4,
    parameter logic [W-1:0]   TAPS = 4'b1100,
    parameter logic [W-1:0]   SEED = 4'b1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            q <= SEED;
        end else if (adv) begin
            q <= {q[W-2:0], fb_bit(MAX_W'(q), MAX_W'(TAPS))};
        end
    end

    // R4
    prpg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        q != '0);

    // R2
    prpg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int           W    = 3,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            sig <= '0;
        end else if (adv) begin
            sig <= {sig[W-2:0], fb_bit(MAX_W'(sig), MAX_W'(TAPS))} ^ resp;
        end
    end

    // R2
    misr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(sig));

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int CYCLES = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      match,
    output bist_ctl_t ctl,
    output logic      busy,
    output logic      done,
    output logic      fail
);

    localparam int            CW   = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    seq_st_e       st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_SEED;
                        done <= 1'b0;
                        fail <= 1'b0;
                    end
                end
                ST_SEED: begin
                    st  <= ST_RUN;
                    cnt <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == LAST) st <= ST_CMP;
                end
                ST_CMP: begin
                    done <= 1'b1;
                    fail <= !match;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (st != ST_IDLE);
        ctl.load    = (st == ST_SEED);
        ctl.adv     = (st == ST_RUN);
        ctl.route   = (st == ST_RUN);
        ctl.isolate = busy;
    end

    // R3
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail)));

    // R9
    start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && start) |=> busy);

endmodule

// File: rtl/lbist_wrap.sv
module lbist_wrap
    import lbist_pkg::*;
#(
    parameter int                 PAT_W    = 4,
    parameter logic [PAT_W-1:0]   PAT_TAPS = 4'b1100,
    parameter logic [PAT_W-1:0]   PAT_SEED = 4'b1000,
    parameter int                 SIG_W    = 3,
    parameter logic [SIG_W-1:0]   SIG_TAPS = 3'b110,
    parameter int                 CYCLES   = 15,
    parameter logic [SIG_W-1:0]   GOLDEN   = 3'b000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PAT_W-1:0] func_in,
    output logic [SIG_W-1:0] func_out,
    output logic [PAT_W-1:0] cut_drive,
    input  logic [SIG_W-1:0] cut_resp,
    output logic             busy,
    output logic             done,
    output logic             fail
);

    bist_ctl_t        ctl;
    logic [PAT_W-1:0] pattern;
    logic [SIG_W-1:0] signature;
    logic             match;

    lbist_seq #(.CYCLES(CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .match (match),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done),
        .fail  (fail)
    );

    lbist_prpg #(.W(PAT_W), .TAPS(PAT_TAPS), .SEED(PAT_SEED)) u_prpg (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .adv  (ctl.adv),
        .q    (pattern)
    );

    lbist_misr #(.W(SIG_W), .TAPS(SIG_TAPS)) u_misr (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .adv  (ctl.adv),
        .resp (cut_resp),
        .sig  (signature)
    );

    assign match     = (signature == GOLDEN);
    assign cut_drive = ctl.route   ? pattern : func_in;
    assign func_out  = ctl.isolate ? '0      : cut_resp;

    // R5
    isolate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (func_out == '0));

endmodule

// File: tb/tb_lbist_wrap.sv
`timescale 1ns/1ps
module tb_lbist_wrap;

    localparam int         CYC  = 15;
    localparam logic [3:0] SEED = 4'b1000;

    function automatic logic [2:0] cut_f(logic [3:0] x);
        return {(&x) ^ x[1], ^x, (x[0] & x[1]) | x[2]};
    endfunction

    function automatic logic [2:0] cut_model(logic [3:0] x, int f);
        case (f)
            1:       return cut_f(x) | 3'b001;
            2:       return cut_f(x) & 3'b011;
            3:       return cut_f(x & 4'b0111);
            default: return cut_f(x);
        endcase
    endfunction

    function automatic logic [3:0] lfsr_step(logic [3:0] p);
        return {p[2:0], p[3] ^ p[2]};
    endfunction

    function automatic logic [2:0] misr_step(logic [2:0] m, logic [2:0] r);
        return {m[1:0], m[2] ^ m[1]} ^ r;
    endfunction

    function automatic logic [2:0] sig_model(int f);
        logic [2:0] m = 3'b000;
        logic [3:0] p = SEED;
        for (int k = 0; k < CYC; k++) begin
            m = misr_step(m, cut_model(p, f));
            p = lfsr_step(p);
        end
        return m;
    endfunction

    localparam logic [2:0] GOLD = sig_model(0);

    logic       clk = 1'b0;
    logic       rst, start;
    logic [3:0] func_in, cut_drive;
    logic [2:0] func_out, cut_resp;
    logic       busy, done, fail;
    int         fault_sel;
    int         errors = 0;
    int         checks = 0;

    always #2.5 clk = ~clk;

    assign cut_resp = cut_model(cut_drive, fault_sel);

    lbist_wrap #(.PAT_W(4), .PAT_TAPS(4'b1100), .PAT_SEED(SEED), .SIG_W(3),
                 .SIG_TAPS(3'b110), .CYCLES(CYC), .GOLDEN(GOLD)) dut (
        .clk(clk), .rst(rst), .start(start), .func_in(func_in),
        .func_out(func_out), .cut_drive(cut_drive), .cut_resp(cut_resp),
        .busy(busy), .done(done), .fail(fail)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_test(int f, bit poke);
        logic [3:0] exp_p = SEED;
        bit         seen [16];
        int         distinct = 0;
        bit         exp_fail;
        for (int i = 0; i < 16; i++) seen[i] = 1'b0;
        fault_sel = f;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R3 busy after start", busy, 1);
        check(done == 1'b0, "R8 done cleared by start", done, 0);
        @(posedge clk);
        for (int k = 0; k < CYC; k++) begin
            @(negedge clk);
            check(cut_drive == exp_p, "R4 pattern", cut_drive, exp_p);
            check(func_out == 3'b000, "R5 isolation", func_out, 0);
            if (!seen[cut_drive] && cut_drive != 4'b0000) distinct++;
            seen[cut_drive] = 1'b1;
            start = (poke && (k == 5 || k == CYC - 1));  // R9 pulses while busy
            exp_p = lfsr_step(exp_p);
            @(posedge clk);
        end
        @(negedge clk) start = 1'b0;
        check(distinct == CYC, "R4 distinct nonzero", distinct, CYC);
        check(busy == 1'b1 && done == 1'b0, "R3 compare cycle", {busy, done}, 2);
        @(posedge clk);
        @(negedge clk);
        exp_fail = (sig_model(f) != GOLD);
        check(done == 1'b1 && busy == 1'b0, "R3 done timing", {busy, done}, 1);
        check(fail == exp_fail, "R6 R7 fail verdict", fail, exp_fail);
        for (int i = 0; i < 4; i++) begin
            func_in = 4'(i * 5 + 1);
            @(negedge clk);
            check(done == 1'b1 && fail == exp_fail, "R8 result hold", fail, exp_fail);
            check(func_out == cut_model(func_in, f), "R2 routing restored",
                  func_out, cut_model(func_in, f));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; func_in = 4'd0; fault_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(done == 1'b0, "R1 done reset", done, 0);
        check(fail == 1'b0, "R1 fail reset", fail, 0);
        // R2: exhaustive normal-mode sweep
        for (int v = 0; v < 16; v++) begin
            @(negedge clk) func_in = 4'(v);
            #1;
            check(cut_drive == 4'(v), "R2 drive pass", cut_drive, v);
            check(func_out == cut_f(4'(v)), "R2 result pass", func_out, cut_f(4'(v)));
        end
        run_test(0, 1'b0);  // R7 fault-free
        run_test(0, 1'b1);  // R9 start during run
        run_test(1, 1'b0);  // R7 output stuck at 1
        run_test(2, 1'b0);  // R7 output stuck at 0
        run_test(3, 1'b0);  // R7 input stuck at 0
        run_test(0, 1'b0);  // R8 new start clears prior fail
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule